// File: doc/BRIEF.md
# Shared-Timer Four-Channel Switch Debouncer

This block cleans up four mechanical switch contacts that operate independently of one another. Each raw contact first passes through a two-stage flip-flop synchronizer. One free-running interval counter serves all four channels. It raises a single-cycle tick each time a full debounce interval has elapsed. Each channel has its own four-state machine. On every tick, the machine samples its synchronized input and moves its clean output to a new level only after two ticks in a row have seen that level.

Several contacts may bounce at the same moment. Each channel's machine keeps its own pending state, so a noisy channel never delays or disturbs a quiet one. The default interval is 50,000 cycles, which is 1 ms at a 50 MHz clock. The clean outputs come up high after reset, which is the released level for switches that pull to ground.

Top module: `mdb_debounce`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every clean output is 1.
- R2: The shared counter ticks once every INTERVAL cycles (16 bits wide at the default of 50,000). A clean output can change only on a clock edge whose count since the reset release is a whole multiple of INTERVAL.
- R3: Each raw input reaches its channel through two flip-flops, so the channel judges a tick by the raw level from two edges earlier.
- R4: A clean output takes a new level only when two consecutive ticks both see the synchronized input at that level. It then changes exactly once.
- R5: If one tick sees the new level and the next tick sees the old level again, the change is abandoned and the clean output does not move.
- R6: The channels are independent. When bouncing happens on several channels at once, each output follows R4 and R5 using only its own input.
- R7: While a synchronized input matches its clean output, that output holds its value indefinitely.
- R8: The same two-tick rule applies to both directions, rising from 0 to 1 and falling from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw_i | input | N_CH | Unfiltered switch contacts, one bit per channel |
| sw_clean_o | output | N_CH | Debounced levels, one bit per channel |

## Verification
A raw level reaches a channel's state machine two edges after it is applied. A change can commit no earlier than the edge of the second tick that follows, and ticks fall on edges whose count since reset is a multiple of INTERVAL. The bench keeps a behavioural model of the counter, the two-edge delay and per-channel agreement counts. The model advances on the same rising edge as the design. The bench compares all four outputs with the model on every falling edge, so each result is checked in the exact cycle it becomes due. It also logs every output transition, checks that its edge count is a multiple of INTERVAL, and counts transitions per scenario to confirm that each channel changes exactly once or not at all.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

    // Sequential encoding; bit 1 is the committed clean level.
    typedef enum logic [1:0] {
        SW_LOW  = 2'd0,
        SW_RISE = 2'd1,
        SW_HIGH = 2'd2,
        SW_FALL = 2'd3
    } sw_state_e;

endpackage

// File: rtl/mdb_timer.sv
module mdb_timer #(
    parameter int unsigned INTERVAL = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = (tmr_q.cnt == LAST);
        if (wrap) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick_o = wrap;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_q.cnt <= LAST);

    generate
        if (INTERVAL > 1) begin : g_pulse_chk
            // R2
            tick_single_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/mdb_sync.sv
module mdb_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter bit          RST_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned WARM_W = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {(STAGES*WIDTH){RST_LEVEL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.chain[STAGES-1];

    // Cycles since reset, saturating; used only to qualify the latency check.
    logic [WARM_W-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != WARM_W'(STAGES)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R3
            sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
                (warm_q == WARM_W'(STAGES)) |-> (sync_o == $past(raw_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/mdb_channel.sv
module mdb_channel
    import mdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic level_i,
    output logic clean_o
);

    typedef struct packed {
        sw_state_e st;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (tick_i) begin
            unique case (ch_q.st)
                SW_LOW:  ch_d.st = level_i ? SW_RISE : SW_LOW;
                SW_RISE: ch_d.st = level_i ? SW_HIGH : SW_LOW;
                SW_HIGH: ch_d.st = level_i ? SW_HIGH : SW_FALL;
                SW_FALL: ch_d.st = level_i ? SW_HIGH : SW_LOW;
                default: ch_d.st = SW_HIGH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q.st <= SW_HIGH;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign clean_o = (ch_q.st == SW_HIGH) || (ch_q.st == SW_FALL);

    // R2
    change_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (clean_o != $past(clean_o)) |-> $past(tick_i));

    // R4
    rise_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_q.st == SW_HIGH && $past(ch_q.st) == SW_LOW) |-> 1'b0);

    // R8
    fall_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_q.st == SW_LOW && $past(ch_q.st) == SW_HIGH) |-> 1'b0);

    // R5
    pending_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_q.st == SW_RISE && tick_i && !level_i) |=> (ch_q.st == SW_LOW));

    // R7
    steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (level_i == clean_o)) |=> (clean_o == $past(clean_o)));

endmodule

// File: rtl/mdb_debounce.sv
module mdb_debounce #(
    parameter int unsigned N_CH        = 4,
    parameter int unsigned INTERVAL    = 50000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] sw_raw_i,
    output logic [N_CH-1:0] sw_clean_o
);

    logic            tick;
    logic [N_CH-1:0] sw_sync;

    mdb_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    mdb_sync #(
        .WIDTH     (N_CH),
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (sw_raw_i),
        .sync_o (sw_sync)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            mdb_channel u_ch (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick),
                .level_i (sw_sync[c]),
                .clean_o (sw_clean_o[c])
            );
        end
    endgenerate

    // R1
    reset_level_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_clean_o == '1));

endmodule

// File: tb/mdb_debounce_tb.sv
module mdb_debounce_tb;

    localparam int N  = 4;
    localparam int IV = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] raw = '1;
    logic [N-1:0] clean;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mdb_debounce #(.N_CH(N), .INTERVAL(IV), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sw_raw_i   (raw),
        .sw_clean_o (clean)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: interval count, two-edge delay, agreement counts.
    int           tcnt;
    int           cyc;
    logic [N-1:0] s1, s2, exp_q;
    int           agree [N];

    always @(posedge clk) begin
        if (rst) begin
            tcnt = 0; cyc = 0; s1 = '1; s2 = '1; exp_q = '1;
            for (int c = 0; c < N; c++) agree[c] = 0;
        end else begin
            bit tk;
            cyc++;
            tk   = (tcnt == IV - 1);
            tcnt = tk ? 0 : tcnt + 1;
            if (tk) begin
                for (int c = 0; c < N; c++) begin
                    if (s2[c] != exp_q[c]) begin
                        agree[c]++;
                        if (agree[c] == 2) begin
                            exp_q[c] = ~exp_q[c];
                            agree[c] = 0;
                        end
                    end else begin
                        agree[c] = 0;
                    end
                end
            end
            s2 = s1;
            s1 = raw;
        end
    end

    // Falling-edge comparison and transition log.
    logic [N-1:0] prev;
    int           trans [N];

    always @(negedge clk) begin
        if (rst) begin
            prev = '1;
        end else if (!done) begin
            chk(clean == exp_q, "R3,R4,R6 model compare", clean, exp_q);
            for (int c = 0; c < N; c++) begin
                if (clean[c] != prev[c]) begin
                    trans[c]++;
                    chk((cyc % IV) == 0, "R2 change on interval edge", cyc % IV, 0);
                end
            end
            prev = clean;
        end
    end

    task automatic clear_trans();
        for (int c = 0; c < N; c++) trans[c] = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < N; c++) trans[c] = 0;
        repeat (4) @(negedge clk);
        chk(clean == '1, "R1 outputs during reset", clean, 4'hF);
        rst = 1'b0;
        @(negedge clk);
        chk(clean == '1, "R1 outputs after reset", clean, 4'hF);

        // R6 R8: all four bounce together toward 0, then hold.
        clear_trans();
        for (int i = 0; i < 30; i++) begin
            for (int c = 0; c < N; c++) raw[c] = (((i * (c + 3)) + c) % 5) < 2;
            @(negedge clk);
        end
        raw = '0;
        wait_cyc(4 * IV);
        for (int c = 0; c < N; c++) begin
            chk(trans[c] == 1, "R4,R6 single fall per channel", trans[c], 1);
            chk(clean[c] == 1'b0, "R8 falling level committed", clean[c], 0);
        end

        // R5: ch2 glitch caught by one tick only; ch3 clean rise meanwhile (R6).
        clear_trans();
        while ((cyc % IV) != IV - 8) @(negedge clk);
        raw[2] = 1'b1;
        raw[3] = 1'b1;
        wait_cyc(12);
        raw[2] = 1'b0;
        wait_cyc(3 * IV);
        chk(trans[2] == 0, "R5 abandoned change", trans[2], 0);
        chk(clean[2] == 1'b0, "R5 output unchanged", clean[2], 0);
        chk(trans[3] == 1, "R6 neighbour commits", trans[3], 1);
        chk(clean[3] == 1'b1, "R8 rising level committed", clean[3], 1);

        // R8 R6: ch0 bounces upward while ch1 and ch2 rise cleanly.
        clear_trans();
        raw[1] = 1'b1;
        raw[2] = 1'b1;
        for (int i = 0; i < 25; i++) begin
            raw[0] = (i % 3) != 0;
            @(negedge clk);
        end
        raw[0] = 1'b1;
        wait_cyc(4 * IV);
        for (int c = 0; c < 3; c++)
            chk(trans[c] == 1, "R4,R8 single rise", trans[c], 1);
        chk(trans[3] == 0, "R7 settled channel holds", trans[3], 0);
        chk(clean == '1, "R8 all high", clean, 4'hF);

        // R7: long steady input.
        clear_trans();
        wait_cyc(5 * IV);
        for (int c = 0; c < N; c++)
            chk(trans[c] == 0, "R7 no change when steady", trans[c], 0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule